// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The RAM has two chip selects, one active low and one active high, plus an active-low write strobe and an active-low read-enable strobe. The host gives a single-cycle request with a 17-bit address, a direction bit and 8 bits of write data. The sequencer then plays out the strobe pattern for that access over a fixed number of clock cycles.

Each speed grade's minimum times are given as nanosecond parameters. They are turned into whole clock counts by rounding up. Between accesses the RAM is left deselected, so it drops into its own low-power standby.

A read returns its byte with a one-cycle valid pulse. Ready is low from the accepting edge until the access time has run out. The block owns the data-bus drive enable, and it never drives the bus while the RAM's outputs are enabled.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and at once when reset is asserted in the middle of an access, ready_o is 1, mem_sel_n_o is 1, mem_sel_o is 0, mem_wr_n_o is 1, mem_rden_n_o is 1, mem_dq_oe_o is 0 and rvalid_o is 0.
- R2: During a write, mem_wr_n_o is low with both selects active for exactly P cycles, where P = max(ceil(tWP/tCLK), ceil(tCW/tCLK)-1, ceil(tDW/tCLK)); 14 cycles at the defaults.
- R3: A write presents the address and active selects for exactly one cycle with mem_wr_n_o high before the strobe falls, and mem_addr_o equals the request address throughout the strobe.
- R4: mem_dq_oe_o is high exactly while mem_wr_n_o is low plus one following cycle (P+1 cycles), and it is never high while mem_rden_n_o is low.
- R5: During a read, mem_wr_n_o stays high and mem_rden_n_o is low from the second cycle of the access to its last, RL-1 cycles, where RL = max(ceil(tAA/tCLK), ceil(tOE/tCLK)+1, ceil(tRC/tCLK)); 18 at the defaults.
- R6: Read data is sampled from mem_dq_i at the clock edge that ends cycle RL of the access. It is presented on rdata_o while rvalid_o is high for exactly one cycle, the cycle right after that edge.
- R7: ready_o is low for exactly WL = max(ceil(tRC/tCLK), P+2) cycles after an accepted write (18 at the defaults) and RL cycles after an accepted read. A request raised while ready_o is low starts no access.
- R8: Whenever ready_o is high, the RAM is deselected (mem_sel_n_o=1, mem_sel_o=0).
- R9: mem_addr_o changes only at an edge where mem_wr_n_o is high both before and after.
- R10: A request presented in the same cycle as rvalid_o is accepted at once, with no idle cycle between the two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken when ready_o is high |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Sequencer idle, request can be taken |
| rdata_o | output | 8 | Read data |
| rvalid_o | output | 1 | One-cycle read-data valid pulse |
| mem_addr_o | output | 17 | RAM address |
| mem_sel_n_o | output | 1 | Active-low chip select |
| mem_sel_o | output | 1 | Active-high chip select |
| mem_wr_n_o | output | 1 | Active-low write strobe |
| mem_rden_n_o | output | 1 | Active-low output enable to the RAM |
| mem_dq_o | output | 8 | Write data to the bus |
| mem_dq_oe_o | output | 1 | Enable for the controller's bus drivers |
| mem_dq_i | input | 8 | Data from the bus |

## Verification
The capture edge is the hardest thing to pin down from the ports. A RAM model that returns a constant would accept a capture that comes one cycle early. The bench's memory model therefore counts the cycles since selection began. Until the access time has run out it drives a poison byte, and only after that the stored byte, so an early capture reads poison. A second hard case is a request that arrives while the sequencer is busy. The directed tests raise such a request in the middle of a write and drop it before the write ends, then look for a stray read strobe. They also issue a read in the exact cycle of the previous valid pulse.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    IDLE, RD_SETUP, RD_WAIT, RD_CAPTURE, WR_SETUP, WR_PULSE, WR_RECOVER
  } seq_state_e;

  // Round a nanosecond minimum up to whole clock cycles.
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Write-strobe width: pulse, select-to-end (one setup cycle already counts), data-valid.
  function automatic int unsigned pulse_len(int unsigned wp, int unsigned cw, int unsigned dw);
    return max2(max2(wp, max2(cw, 1) - 1), dw);
  endfunction

  // Read occupancy: address access, output-enable access after setup, cycle time.
  function automatic int unsigned read_len(int unsigned aa, int unsigned oe, int unsigned cyc);
    return max2(max2(aa, oe + 1), max2(cyc, 3));
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
`timescale 1ns/1ps
module sram_seq_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned PULSE_C = 14,
  parameter int unsigned REC_C   = 3,
  parameter int unsigned RDW_C   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_wr,
  output seq_state_e state,
  output logic       dq_oe,
  output logic       ev_accept,
  output logic       ev_capture
);
  seq_state_e       nxt;
  logic             t_load, t_done;
  logic [CNT_W-1:0] t_val;

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  always_comb begin
    nxt        = state;
    t_load     = 1'b0;
    t_val      = '0;
    ev_accept  = 1'b0;
    ev_capture = 1'b0;
    unique case (state)
      IDLE: if (req) begin
        ev_accept = 1'b1;
        nxt       = req_wr ? WR_SETUP : RD_SETUP;
      end
      RD_SETUP: begin
        nxt = RD_WAIT; t_load = 1'b1; t_val = CNT_W'(RDW_C - 1);
      end
      RD_WAIT:    if (t_done) nxt = RD_CAPTURE;
      RD_CAPTURE: begin ev_capture = 1'b1; nxt = IDLE; end
      WR_SETUP: begin
        nxt = WR_PULSE; t_load = 1'b1; t_val = CNT_W'(PULSE_C - 1);
      end
      WR_PULSE: if (t_done) begin
        nxt = WR_RECOVER; t_load = 1'b1; t_val = CNT_W'(REC_C - 1);
      end
      WR_RECOVER: if (t_done) nxt = IDLE;
      default:    nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      dq_oe <= 1'b0;
    end else begin
      state <= nxt;
      // drive through the strobe and one hold cycle after it
      dq_oe <= (nxt == WR_PULSE) || (state == WR_PULSE);
    end
  end
endmodule

// File: rtl/sram_seq_datapath.sv
`timescale 1ns/1ps
module sram_seq_datapath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept,
  input  logic              ev_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (ev_accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (ev_capture) rdata_q <= bus_in;
      rvalid_q <= ev_capture;
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_NS     = 4,
  parameter int unsigned T_CYCLE_NS = 70,
  parameter int unsigned T_WP_NS    = 50,
  parameter int unsigned T_CW_NS    = 60,
  parameter int unsigned T_DW_NS    = 30,
  parameter int unsigned T_AA_NS    = 70,
  parameter int unsigned T_OE_NS    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_sel_n_o,
  output logic              mem_sel_o,
  output logic              mem_wr_n_o,
  output logic              mem_rden_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned CYC_C     = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int unsigned PULSE_CYC = pulse_len(ns_to_cyc(T_WP_NS, CLK_NS),
                                                ns_to_cyc(T_CW_NS, CLK_NS),
                                                ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int unsigned REC_CYC   = (CYC_C > PULSE_CYC + 2) ? CYC_C - 1 - PULSE_CYC : 1;
  localparam int unsigned RD_LEN    = read_len(ns_to_cyc(T_AA_NS, CLK_NS),
                                               ns_to_cyc(T_OE_NS, CLK_NS), CYC_C);
  localparam int unsigned RDW_CYC   = RD_LEN - 2;
  localparam int unsigned MAX_LD    = max2(max2(PULSE_CYC, REC_CYC), RDW_CYC);
  localparam int unsigned CNT_W     = $clog2(MAX_LD + 1);

  seq_state_e state;
  logic       dq_oe, ev_accept, ev_capture;
  logic       st_idle, st_pulse, st_rd_on;

  sram_seq_fsm #(
    .CNT_W(CNT_W), .PULSE_C(PULSE_CYC), .REC_C(REC_CYC), .RDW_C(RDW_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req_i), .req_wr(req_wr_i),
    .state(state), .dq_oe(dq_oe), .ev_accept(ev_accept), .ev_capture(ev_capture)
  );

  sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept), .ev_capture(ev_capture),
    .req_addr(req_addr_i), .req_wdata(req_wdata_i), .bus_in(mem_dq_i),
    .addr_q(mem_addr_o), .wdata_q(mem_dq_o), .rdata_q(rdata_o), .rvalid_q(rvalid_o)
  );

  assign st_idle  = (state == IDLE);
  assign st_pulse = (state == WR_PULSE);
  assign st_rd_on = (state == RD_WAIT) || (state == RD_CAPTURE);

  assign ready_o      = st_idle;
  assign mem_sel_n_o  = st_idle;
  assign mem_sel_o    = !st_idle;
  assign mem_wr_n_o   = !st_pulse;
  assign mem_rden_n_o = !st_rd_on;
  assign mem_dq_oe_o  = dq_oe;
endmodule

// File: rtl/sram_seq_chk.sv
`timescale 1ns/1ps
module sram_seq_chk #(
  parameter int unsigned PULSE_CYC = 14,
  parameter int unsigned ADDR_W    = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_sel_n_o,
  input logic              mem_sel_o,
  input logic              mem_wr_n_o,
  input logic              mem_rden_n_o,
  input logic              mem_dq_oe_o,
  input logic              ev_accept,
  input logic              ev_capture
);
  logic [15:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_cnt <= '0;
    else if (!mem_wr_n_o) low_cnt <= low_cnt + 1'b1;
    else                  low_cnt <= '0;
  end

  assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n_o) |-> low_cnt == 16'(PULSE_CYC));
  assert_wr_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n_o) |-> $past(!mem_sel_n_o && mem_sel_o));
  assert_bus_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe_o |-> mem_rden_n_o);
  assert_dq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n_o) |-> mem_dq_oe_o);
  assert_rd_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rden_n_o |-> (mem_wr_n_o && !mem_sel_n_o && mem_sel_o));
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> rvalid_o);
  assert_rvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |=> !rvalid_o);
  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !ready_o);
  assert_idle_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (mem_sel_n_o && !mem_sel_o));
  assert_addr_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr_o) |-> (mem_wr_n_o && $past(mem_wr_n_o)));
endmodule

bind sram_seq_ctrl sram_seq_chk #(.PULSE_CYC(PULSE_CYC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_o(ready_o), .rvalid_o(rvalid_o),
  .mem_addr_o(mem_addr_o), .mem_sel_n_o(mem_sel_n_o), .mem_sel_o(mem_sel_o),
  .mem_wr_n_o(mem_wr_n_o), .mem_rden_n_o(mem_rden_n_o), .mem_dq_oe_o(mem_dq_oe_o),
  .ev_accept(ev_accept), .ev_capture(ev_capture)
);

// File: tb/sram_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb;
  localparam int CK = 4;
  function automatic int up(int ns);
    return ns / CK + ((ns % CK) != 0 ? 1 : 0);
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction
  localparam int EXP_P  = mx(mx(up(50), up(60) - 1), up(30));
  localparam int EXP_WL = mx(up(70), EXP_P + 2);
  localparam int EXP_RL = mx(mx(up(70), up(40) + 1), up(70));

  // {write, address, data (write data or expected read data)}
  localparam logic [25:0] VEC [0:7] = '{
    {1'b1, 17'h00005, 8'hA5}, {1'b1, 17'h1FFC3, 8'h3C},
    {1'b0, 17'h00005, 8'hA5}, {1'b0, 17'h1FFC3, 8'h3C},
    {1'b1, 17'h10000, 8'hFF}, {1'b1, 17'h00021, 8'h00},
    {1'b0, 17'h10000, 8'hFF}, {1'b0, 17'h00021, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ready_o, rvalid_o, mem_sel_n_o, mem_sel_o, mem_wr_n_o, mem_rden_n_o, mem_dq_oe_o;
  logic [7:0]  rdata_o, mem_dq_o, mem_dq_i;
  logic [16:0] mem_addr_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  sram_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_wr_i(req_wr), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .mem_addr_o(mem_addr_o), .mem_sel_n_o(mem_sel_n_o), .mem_sel_o(mem_sel_o),
    .mem_wr_n_o(mem_wr_n_o), .mem_rden_n_o(mem_rden_n_o), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
  );

  // Sparse RAM model: 64 slots by low address bits, tagged with the high bits.
  logic [7:0]  m_data [64];
  logic [10:0] m_tag  [64];
  logic        m_ok   [64];
  int          age;
  wire         sel_on = !mem_sel_n_o && mem_sel_o;

  initial for (int i = 0; i < 64; i++) begin m_data[i] = '0; m_tag[i] = '0; m_ok[i] = 1'b0; end

  always @(posedge clk) begin
    age <= (sel_on && mem_wr_n_o) ? age + 1 : 0;
    if (sel_on && !mem_wr_n_o && mem_dq_oe_o) begin
      m_data[mem_addr_o[5:0]] <= mem_dq_o;
      m_tag[mem_addr_o[5:0]]  <= mem_addr_o[16:6];
      m_ok[mem_addr_o[5:0]]   <= 1'b1;
    end
  end

  always_comb begin
    if (sel_on && mem_wr_n_o && !mem_rden_n_o && age >= EXP_RL - 1)
      mem_dq_i = (m_ok[mem_addr_o[5:0]] && m_tag[mem_addr_o[5:0]] == mem_addr_o[16:6])
                 ? m_data[mem_addr_o[5:0]] : 8'h00;
    else
      mem_dq_i = 8'hEE;  // not yet valid
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic idle_state(input string tag);
    check(tag, {ready_o, mem_sel_n_o, mem_sel_o, mem_wr_n_o, mem_rden_n_o, mem_dq_oe_o, rvalid_o},
          7'b1101100);
  endtask

  // Called on a negedge; returns on the negedge where ready_o is high again.
  task automatic do_op(input logic wr, input logic [16:0] a, input logic [7:0] d);
    int busy = 0, wl = 0, oe = 0, rl = 0, setup = 0, bad_addr = 0, clash = 0;
    bit seen_wr = 0;
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (!ready_o && busy < 100) begin
      busy++;
      if (!mem_wr_n_o) begin
        wl++; seen_wr = 1;
        if (mem_addr_o !== a) bad_addr++;
      end else if (!seen_wr && wr && sel_on) setup++;
      if (mem_dq_oe_o) oe++;
      if (mem_dq_oe_o && !mem_rden_n_o) clash++;
      if (!mem_rden_n_o) rl++;
      @(negedge clk);
    end
    check("R4 no bus clash", clash, 0);
    if (wr) begin
      check("R7 write busy", busy, EXP_WL);
      check("R2 strobe width", wl, EXP_P);
      check("R3 setup cycles", setup, 1);
      check("R3 address during strobe", bad_addr, 0);
      check("R4 drive cycles", oe, EXP_P + 1);
      check("R5 no rden in write", rl, 0);
    end else begin
      check("R7 read busy", busy, EXP_RL);
      check("R5 rden cycles", rl, EXP_RL - 1);
      check("R2 no strobe in read", wl, 0);
      check("R6 rvalid", rvalid_o, 1);
      check("R6 rdata", rdata_o, d);
    end
    check("R8 deselected when ready", {mem_sel_n_o, mem_sel_o}, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int rd;
    repeat (3) @(negedge clk);
    idle_state("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_state("R1 after reset");

    for (int i = 0; i < 8; i++) do_op(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);

    // Back-to-back: next read issued in the rvalid cycle of the previous one.
    do_op(1'b0, 17'h00005, 8'hA5);
    req = 1'b1; req_wr = 1'b0; req_addr = 17'h1FFC3;
    @(negedge clk);
    req = 1'b0;
    check("R10 accepted in rvalid cycle", ready_o, 0);
    check("R6 rvalid single cycle", rvalid_o, 0);
    while (!ready_o) @(negedge clk);
    check("R10 second read data", rdata_o, 8'h3C);

    // Request raised while busy must be ignored.
    req = 1'b1; req_wr = 1'b1; req_addr = 17'h0000A; req_wdata = 8'h77;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_addr = 17'h00001;
    rd = 0;
    repeat (3) begin if (!mem_rden_n_o) rd++; @(negedge clk); end
    req = 1'b0;
    while (!ready_o) begin if (!mem_rden_n_o) rd++; @(negedge clk); end
    repeat (3) begin if (!mem_rden_n_o) rd++; @(negedge clk); end
    check("R7 busy request ignored", rd, 0);
    check("R8 idle stays deselected", {ready_o, mem_sel_n_o, mem_sel_o}, 3'b110);
    do_op(1'b0, 17'h0000A, 8'h77);

    // Reset in the middle of a write strobe.
    req = 1'b1; req_wr = 1'b1; req_addr = 17'h00030; req_wdata = 8'h12;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 strobe active before reset", mem_wr_n_o, 0);
    rst_n = 1'b0;
    #1;
    idle_state("R1 reset mid-write");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_state("R1 after mid-write reset");

    summary();
    $finish;
  end
endmodule